// File: doc/BRIEF.md
# Trap Entry State Unit

This unit performs the control-state update that a register-window processor makes when it takes an ordinary trap into privileged mode. When `trapValid` is high for one cycle, the unit reads the trap type, the live control registers and the current program counters. On the next clock edge it publishes the post-trap control state. In the same edge it records the pre-trap context in a trap stack, one entry per trap nesting level.

The window pointer moves by an amount that depends on the trap type. Window-spill and window-fill traps also redirect fetch to fixed handler base addresses. A request that arrives while the nesting level is already at its maximum is refused: the unit flags an error and changes no state. A combinational read port returns the saved context of any nesting level, so the trap stack can be inspected.

Top module: `trap_entry_unit`

## Requirements
- R1: Synchronous reset sets `tlOut` to 0 and sets every output and every trap-stack entry to zero. Each accepted trap raises `tlOut` by exactly 1 on the next clock edge.
- R2: The saved state word of the new level holds the following fields: GL in bits 42:40, CCR in bits 39:32, ASI in bits 31:24, the pre-trap PSTATE in bits 20:8 and the pre-trap CWP, zero-extended, in bits 4:0. All other bits are zero.
- R3: The new level's entry also stores the pre-trap PC, the pre-trap NPC, the hyperprivileged state word and the 9-bit trap type.
- R4: The new PSTATE is the old value with these changes: bit 4 is set, bit 3 is cleared, bit 2 is set, bit 1 is cleared, and bit 9 takes the old value of bit 8. All other bits are kept.
- R5: The new GL is the old GL plus one, saturating at the parameter `MAX_GL`.
- R6: Trap type 0x024 moves CWP up by 1, modulo `NWINDOWS`.
- R7: Trap types 0x080 to 0x0BF (spill) move CWP up by CANSAVE+2, modulo `NWINDOWS`.
- R8: Trap types 0x0C0 to 0x0FF (fill) move CWP down by 1, modulo `NWINDOWS`. Every other trap type, including any type with bit 8 set, leaves CWP at its input value.
- R9: On a spill trap, `pcOut` becomes `SPILL_BASE`, `npcOut` becomes base+4 and `nnpcOut` becomes base+8, and `redirect` pulses for one cycle. A fill trap does the same with `FILL_BASE`. On any other trap, `redirect` stays low and the three PC outputs keep their previous values.
- R10: A request while `tlOut` equals `MAXTL` pulses `trapErr`. It leaves `tlOut`, every other output and the whole trap stack unchanged.
- R11: The read port is combinational. For `rdLevel` values 1 to `MAXTL` it returns that level's saved entry; for any other value it returns zero.
- R12: An accepted trap updates all outputs on the first clock edge after `trapValid` and pulses `entryDone` for that one cycle. Without a request, `tlOut` holds and `entryDone` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trapValid | input | 1 | One-cycle trap request |
| trapType | input | 9 | Trap type |
| curPstate | input | 13 | Current processor state word |
| curHpstate | input | HPS_W | Current hyperprivileged state word |
| curCcr | input | 8 | Current condition codes |
| curAsi | input | 8 | Current address space identifier |
| curCwp | input | clog2(NWINDOWS) | Current window pointer |
| curCansave | input | clog2(NWINDOWS) | Count of windows free to save into |
| curGl | input | 3 | Current global register level |
| curPc | input | ADDR_W | Current PC |
| curNpc | input | ADDR_W | Current next PC |
| rdLevel | input | clog2(MAXTL+1) | Trap stack level to read |
| tlOut | output | clog2(MAXTL+1) | Trap nesting level |
| pstateOut | output | 13 | Post-trap processor state word |
| glOut | output | 3 | Post-trap global level |
| cwpOut | output | clog2(NWINDOWS) | Post-trap window pointer |
| pcOut | output | ADDR_W | Redirected PC |
| npcOut | output | ADDR_W | Redirected next PC |
| nnpcOut | output | ADDR_W | Redirected next-next PC |
| redirect | output | 1 | Pulse: fetch redirect to a handler |
| entryDone | output | 1 | Pulse: trap accepted |
| trapErr | output | 1 | Pulse: request refused at maximum level |
| rdTstate | output | 43 | Saved state word at `rdLevel` |
| rdTpc | output | ADDR_W | Saved PC at `rdLevel` |
| rdTnpc | output | ADDR_W | Saved next PC at `rdLevel` |
| rdHtstate | output | HPS_W | Saved hyperprivileged word at `rdLevel` |
| rdTt | output | 9 | Saved trap type at `rdLevel` |

## Verification
A wrong nesting level shows on `tlOut` one edge after the request. It also misplaces the saved entry, and the read port exposes that in the same cycle. A wrong decode of the trap-type ranges shows as a wrong `cwpOut` on that same edge. It can also show as a missing or spurious `redirect` pulse, with stale PC outputs. A faulty refusal at the maximum level shows as a `tlOut` change or as an altered top entry, rather than as a `trapErr` pulse. The corner cases exercised are window wrap in both directions, the edges of each range, type values with bit 8 set, and GL saturation.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int TSTATE_W = 43;
  localparam int PST_W    = 13;
  localparam int GL_W     = 3;
  localparam int TT_W     = 9;
  localparam int BYTE_W   = 8;
  localparam int CWPF_W   = 5;

  typedef enum logic [1:0] {
    CWP_KEEP  = 2'd0,
    CWP_INC   = 2'd1,
    CWP_SPILL = 2'd2,
    CWP_DEC   = 2'd3
  } cwpMode_e;

  typedef struct packed {
    logic     accept;
    logic     reject;
    logic     toSpill;
    logic     toFill;
    cwpMode_e cwpMode;
  } trapStrobes_t;
endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int MAXTL = 6,
  localparam int TL_W = $clog2(MAXTL + 1)
) (
  input  logic              trapValid,
  input  logic [TT_W-1:0]   trapType,
  input  logic [TL_W-1:0]   curTl,
  output trapStrobes_t      strobes
);
  logic atTop;
  logic isSpill;
  logic isFill;
  logic isWinInc;

  assign atTop    = (curTl == TL_W'(MAXTL));
  assign isSpill  = (trapType[8:6] == 3'b010);
  assign isFill   = (trapType[8:6] == 3'b011);
  assign isWinInc = (trapType == 9'h024);

  always_comb begin
    strobes.accept  = trapValid && !atTop;
    strobes.reject  = trapValid && atTop;
    strobes.toSpill = trapValid && !atTop && isSpill;
    strobes.toFill  = trapValid && !atTop && isFill;
    if (isWinInc)     strobes.cwpMode = CWP_INC;
    else if (isSpill) strobes.cwpMode = CWP_SPILL;
    else if (isFill)  strobes.cwpMode = CWP_DEC;
    else              strobes.cwpMode = CWP_KEEP;
  end
endmodule

// File: rtl/trap_entry_datapath.sv
module trap_entry_datapath
  import trap_entry_pkg::*;
#(
  parameter int NWINDOWS = 8,
  parameter int MAXTL = 6,
  parameter int MAX_GL = 5,
  parameter int HPS_W = 12,
  parameter int ADDR_W = 64,
  parameter logic [ADDR_W-1:0] SPILL_BASE = 64'h0000_0100_0000_0080,
  parameter logic [ADDR_W-1:0] FILL_BASE  = 64'h0000_0100_0000_0000,
  localparam int TL_W = $clog2(MAXTL + 1),
  localparam int CWP_W = $clog2(NWINDOWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  trapStrobes_t        strobes,
  input  logic [TT_W-1:0]     trapType,
  input  logic [PST_W-1:0]    curPstate,
  input  logic [HPS_W-1:0]    curHpstate,
  input  logic [BYTE_W-1:0]   curCcr,
  input  logic [BYTE_W-1:0]   curAsi,
  input  logic [CWP_W-1:0]    curCwp,
  input  logic [CWP_W-1:0]    curCansave,
  input  logic [GL_W-1:0]     curGl,
  input  logic [ADDR_W-1:0]   curPc,
  input  logic [ADDR_W-1:0]   curNpc,
  input  logic [TL_W-1:0]     rdLevel,
  output logic [TL_W-1:0]     tlOut,
  output logic [PST_W-1:0]    pstateOut,
  output logic [GL_W-1:0]     glOut,
  output logic [CWP_W-1:0]    cwpOut,
  output logic [ADDR_W-1:0]   pcOut,
  output logic [ADDR_W-1:0]   npcOut,
  output logic [ADDR_W-1:0]   nnpcOut,
  output logic                redirect,
  output logic                entryDone,
  output logic                trapErr,
  output logic [TSTATE_W-1:0] rdTstate,
  output logic [ADDR_W-1:0]   rdTpc,
  output logic [ADDR_W-1:0]   rdTnpc,
  output logic [HPS_W-1:0]    rdHtstate,
  output logic [TT_W-1:0]     rdTt
);
  localparam int SUM_W = CWP_W + 2;
  localparam logic [SUM_W-1:0] NWIN_S = SUM_W'(NWINDOWS);
  localparam logic [ADDR_W-1:0] INST_B = ADDR_W'(4);

  logic [TSTATE_W-1:0] stkTstate  [1:MAXTL];
  logic [ADDR_W-1:0]   stkTpc     [1:MAXTL];
  logic [ADDR_W-1:0]   stkTnpc    [1:MAXTL];
  logic [HPS_W-1:0]    stkHtstate [1:MAXTL];
  logic [TT_W-1:0]     stkTt      [1:MAXTL];

  logic [TL_W-1:0]     newTl;
  logic [TSTATE_W-1:0] packedState;
  logic [PST_W-1:0]    pstateNext;
  logic [GL_W-1:0]     glNext;
  logic [SUM_W-1:0]    cwpSum;
  logic [CWP_W-1:0]    cwpNext;
  logic [ADDR_W-1:0]   handlerBase;
  logic                rdInRange;

  assign newTl = tlOut + 1'b1;

  assign packedState = {curGl, curCcr, curAsi, 3'b000, curPstate, 3'b000,
                        CWPF_W'(curCwp)};

  always_comb begin
    pstateNext    = curPstate;
    pstateNext[4] = 1'b1;
    pstateNext[3] = 1'b0;
    pstateNext[2] = 1'b1;
    pstateNext[9] = curPstate[8];
    pstateNext[1] = 1'b0;
  end

  assign glNext = (curGl >= GL_W'(MAX_GL)) ? GL_W'(MAX_GL) : curGl + 1'b1;

  always_comb begin
    unique case (strobes.cwpMode)
      CWP_INC:   cwpSum = SUM_W'(curCwp) + SUM_W'(1);
      CWP_SPILL: cwpSum = SUM_W'(curCwp) + SUM_W'(curCansave) + SUM_W'(2);
      CWP_DEC:   cwpSum = SUM_W'(curCwp) + NWIN_S - SUM_W'(1);
      default:   cwpSum = SUM_W'(curCwp);
    endcase
    cwpNext = CWP_W'(cwpSum % NWIN_S);
  end

  assign handlerBase = strobes.toSpill ? SPILL_BASE : FILL_BASE;

  always_ff @(posedge clk) begin
    if (rst) begin
      tlOut     <= '0;
      pstateOut <= '0;
      glOut     <= '0;
      cwpOut    <= '0;
      pcOut     <= '0;
      npcOut    <= '0;
      nnpcOut   <= '0;
      redirect  <= 1'b0;
      entryDone <= 1'b0;
      trapErr   <= 1'b0;
      for (int i = 1; i <= MAXTL; i++) begin
        stkTstate[i]  <= '0;
        stkTpc[i]     <= '0;
        stkTnpc[i]    <= '0;
        stkHtstate[i] <= '0;
        stkTt[i]      <= '0;
      end
    end else begin
      redirect  <= strobes.toSpill || strobes.toFill;
      entryDone <= strobes.accept;
      trapErr   <= strobes.reject;
      if (strobes.accept) begin
        tlOut             <= newTl;
        pstateOut         <= pstateNext;
        glOut             <= glNext;
        cwpOut            <= cwpNext;
        stkTstate[newTl]  <= packedState;
        stkTpc[newTl]     <= curPc;
        stkTnpc[newTl]    <= curNpc;
        stkHtstate[newTl] <= curHpstate;
        stkTt[newTl]      <= trapType;
      end
      if (strobes.toSpill || strobes.toFill) begin
        pcOut   <= handlerBase;
        npcOut  <= handlerBase + INST_B;
        nnpcOut <= handlerBase + INST_B + INST_B;
      end
    end
  end

  assign rdInRange = (rdLevel != '0) && (rdLevel <= TL_W'(MAXTL));

  always_comb begin
    rdTstate  = '0;
    rdTpc     = '0;
    rdTnpc    = '0;
    rdHtstate = '0;
    rdTt      = '0;
    if (rdInRange) begin
      rdTstate  = stkTstate[rdLevel];
      rdTpc     = stkTpc[rdLevel];
      rdTnpc    = stkTnpc[rdLevel];
      rdHtstate = stkHtstate[rdLevel];
      rdTt      = stkTt[rdLevel];
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int NWINDOWS = 8,
  parameter int MAXTL = 6,
  parameter int MAX_GL = 5,
  parameter int HPS_W = 12,
  parameter int ADDR_W = 64,
  parameter logic [ADDR_W-1:0] SPILL_BASE = 64'h0000_0100_0000_0080,
  parameter logic [ADDR_W-1:0] FILL_BASE  = 64'h0000_0100_0000_0000
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              trapValid,
  input  logic [8:0]                        trapType,
  input  logic [12:0]                       curPstate,
  input  logic [HPS_W-1:0]                  curHpstate,
  input  logic [7:0]                        curCcr,
  input  logic [7:0]                        curAsi,
  input  logic [$clog2(NWINDOWS)-1:0]       curCwp,
  input  logic [$clog2(NWINDOWS)-1:0]       curCansave,
  input  logic [2:0]                        curGl,
  input  logic [ADDR_W-1:0]                 curPc,
  input  logic [ADDR_W-1:0]                 curNpc,
  input  logic [$clog2(MAXTL+1)-1:0]        rdLevel,
  output logic [$clog2(MAXTL+1)-1:0]        tlOut,
  output logic [12:0]                       pstateOut,
  output logic [2:0]                        glOut,
  output logic [$clog2(NWINDOWS)-1:0]       cwpOut,
  output logic [ADDR_W-1:0]                 pcOut,
  output logic [ADDR_W-1:0]                 npcOut,
  output logic [ADDR_W-1:0]                 nnpcOut,
  output logic                              redirect,
  output logic                              entryDone,
  output logic                              trapErr,
  output logic [42:0]                       rdTstate,
  output logic [ADDR_W-1:0]                 rdTpc,
  output logic [ADDR_W-1:0]                 rdTnpc,
  output logic [HPS_W-1:0]                  rdHtstate,
  output logic [8:0]                        rdTt
);
  trapStrobes_t strobes;

  trap_entry_ctrl #(.MAXTL(MAXTL)) ctrl_i (
    .trapValid (trapValid),
    .trapType  (trapType),
    .curTl     (tlOut),
    .strobes   (strobes)
  );

  trap_entry_datapath #(
    .NWINDOWS   (NWINDOWS),
    .MAXTL      (MAXTL),
    .MAX_GL     (MAX_GL),
    .HPS_W      (HPS_W),
    .ADDR_W     (ADDR_W),
    .SPILL_BASE (SPILL_BASE),
    .FILL_BASE  (FILL_BASE)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .trapType   (trapType),
    .curPstate  (curPstate),
    .curHpstate (curHpstate),
    .curCcr     (curCcr),
    .curAsi     (curAsi),
    .curCwp     (curCwp),
    .curCansave (curCansave),
    .curGl      (curGl),
    .curPc      (curPc),
    .curNpc     (curNpc),
    .rdLevel    (rdLevel),
    .tlOut      (tlOut),
    .pstateOut  (pstateOut),
    .glOut      (glOut),
    .cwpOut     (cwpOut),
    .pcOut      (pcOut),
    .npcOut     (npcOut),
    .nnpcOut    (nnpcOut),
    .redirect   (redirect),
    .entryDone  (entryDone),
    .trapErr    (trapErr),
    .rdTstate   (rdTstate),
    .rdTpc      (rdTpc),
    .rdTnpc     (rdTnpc),
    .rdHtstate  (rdHtstate),
    .rdTt       (rdTt)
  );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int NWINDOWS = 8,
  parameter int MAXTL = 6,
  parameter int MAX_GL = 5,
  parameter int ADDR_W = 64
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        trapValid,
  input logic [$clog2(MAXTL+1)-1:0]  tlOut,
  input logic [2:0]                  glOut,
  input logic [$clog2(NWINDOWS)-1:0] cwpOut,
  input logic [ADDR_W-1:0]           pcOut,
  input logic [ADDR_W-1:0]           npcOut,
  input logic [ADDR_W-1:0]           nnpcOut,
  input logic                        redirect,
  input logic                        entryDone,
  input logic                        trapErr
);
  // R1
  tl_step_chk: assert property (@(posedge clk) disable iff (rst)
    (trapValid && tlOut < MAXTL) |=> (tlOut == $past(tlOut) + 1'b1));

  // R1
  tl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tlOut <= MAXTL);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (trapValid && tlOut == MAXTL) |=> (trapErr && !entryDone && $stable(tlOut)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !trapValid |=> ($stable(tlOut) && !entryDone && !trapErr && !redirect));

  // R9
  redir_seq_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (npcOut == pcOut + 4 && nnpcOut == pcOut + 8 && entryDone));

  // R5
  gl_cap_chk: assert property (@(posedge clk) disable iff (rst)
    glOut <= MAX_GL);

  // R6
  cwp_range_chk: assert property (@(posedge clk) disable iff (rst)
    cwpOut < NWINDOWS);
endmodule

bind trap_entry_unit trap_entry_chk #(
  .NWINDOWS (NWINDOWS),
  .MAXTL    (MAXTL),
  .MAX_GL   (MAX_GL),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .trapValid (trapValid),
  .tlOut     (tlOut),
  .glOut     (glOut),
  .cwpOut    (cwpOut),
  .pcOut     (pcOut),
  .npcOut    (npcOut),
  .nnpcOut   (nnpcOut),
  .redirect  (redirect),
  .entryDone (entryDone),
  .trapErr   (trapErr)
);

// File: tb/trap_entry_unit_tb_top.sv
module trap_entry_unit_tb_top;
  localparam int NW = 8;
  localparam int MTL = 6;
  localparam int MGL = 5;
  localparam logic [63:0] SPB = 64'h0000_0100_0000_0080;
  localparam logic [63:0] FLB = 64'h0000_0100_0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trapValid = 1'b0;
  logic [8:0] trapType = '0;
  logic [12:0] curPstate = '0;
  logic [11:0] curHpstate = '0;
  logic [7:0] curCcr = '0, curAsi = '0;
  logic [2:0] curCwp = '0, curCansave = '0, curGl = '0;
  logic [63:0] curPc = '0, curNpc = '0;
  logic [2:0] rdLevel = '0;
  logic [2:0] tlOut, glOut, cwpOut;
  logic [12:0] pstateOut;
  logic [63:0] pcOut, npcOut, nnpcOut, rdTpc, rdTnpc;
  logic redirect, entryDone, trapErr;
  logic [42:0] rdTstate;
  logic [11:0] rdHtstate;
  logic [8:0] rdTt;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  trap_entry_unit dut_i (
    .clk(clk), .rst(rst), .trapValid(trapValid), .trapType(trapType),
    .curPstate(curPstate), .curHpstate(curHpstate), .curCcr(curCcr),
    .curAsi(curAsi), .curCwp(curCwp), .curCansave(curCansave), .curGl(curGl),
    .curPc(curPc), .curNpc(curNpc), .rdLevel(rdLevel), .tlOut(tlOut),
    .pstateOut(pstateOut), .glOut(glOut), .cwpOut(cwpOut), .pcOut(pcOut),
    .npcOut(npcOut), .nnpcOut(nnpcOut), .redirect(redirect),
    .entryDone(entryDone), .trapErr(trapErr), .rdTstate(rdTstate),
    .rdTpc(rdTpc), .rdTnpc(rdTnpc), .rdHtstate(rdHtstate), .rdTt(rdTt)
  );

  typedef struct {
    logic [2:0]  tl, gl, cwp, level;
    logic [12:0] pst;
    logic [63:0] pc, npc, nnpc, tpc, tnpc;
    logic        redir, done, err;
    logic [42:0] tst;
    logic [11:0] hts;
    logic [8:0]  tt;
  } exp_t;

  exp_t sbQ[$];

  logic [2:0]  mTl, mGl, mCwp;
  logic [12:0] mPst;
  logic [63:0] mPc, mNpc, mNnpc;
  logic [42:0] mTst [1:MTL];
  logic [63:0] mTpc [1:MTL];
  logic [63:0] mTnpc [1:MTL];
  logic [11:0] mHts [1:MTL];
  logic [8:0]  mTt [1:MTL];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mTl = 0; mGl = 0; mCwp = 0; mPst = 0; mPc = 0; mNpc = 0; mNnpc = 0;
    for (int i = 1; i <= MTL; i++) begin
      mTst[i] = 0; mTpc[i] = 0; mTnpc[i] = 0; mHts[i] = 0; mTt[i] = 0;
    end
  endtask

  // Driver: applies one request and pushes the expected result.
  task automatic doTrap(logic [8:0] tt, logic [12:0] pst, logic [11:0] hps,
                        logic [7:0] ccr, logic [7:0] asi, logic [2:0] cwp,
                        logic [2:0] cs, logic [2:0] gl, logic [63:0] pc);
    exp_t e;
    int c;
    logic [63:0] base;
    @(negedge clk);
    trapType = tt; curPstate = pst; curHpstate = hps; curCcr = ccr;
    curAsi = asi; curCwp = cwp; curCansave = cs; curGl = gl;
    curPc = pc; curNpc = pc + 4; trapValid = 1'b1;
    e.redir = 0; e.done = 0; e.err = 0;
    if (mTl == MTL) begin
      e.err = 1;
    end else begin
      e.done = 1;
      mTl = mTl + 1;
      mTst[mTl] = {gl, ccr, asi, 3'b0, pst, 3'b0, 2'b0, cwp};
      mTpc[mTl] = pc; mTnpc[mTl] = pc + 4; mHts[mTl] = hps; mTt[mTl] = tt;
      mPst = pst; mPst[4] = 1; mPst[3] = 0; mPst[2] = 1; mPst[9] = pst[8]; mPst[1] = 0;
      mGl = (gl >= MGL) ? 3'(MGL) : gl + 1;
      c = cwp;
      if (tt == 9'h024) c = c + 1;
      else if (tt >= 9'h080 && tt <= 9'h0BF) c = c + cs + 2;
      else if (tt >= 9'h0C0 && tt <= 9'h0FF) c = c - 1;
      mCwp = 3'(((c % NW) + NW) % NW);
      if (tt >= 9'h080 && tt <= 9'h0FF) begin
        base = (tt <= 9'h0BF) ? SPB : FLB;
        e.redir = 1; mPc = base; mNpc = base + 4; mNnpc = base + 8;
      end
    end
    e.tl = mTl; e.gl = mGl; e.cwp = mCwp; e.pst = mPst;
    e.pc = mPc; e.npc = mNpc; e.nnpc = mNnpc;
    e.level = e.err ? 3'(MTL) : mTl;
    e.tst = mTst[e.level]; e.tpc = mTpc[e.level]; e.tnpc = mTnpc[e.level];
    e.hts = mHts[e.level]; e.tt = mTt[e.level];
    sbQ.push_back(e);
    @(negedge clk);
    trapValid = 1'b0;
  endtask

  // Monitor: compares one edge after each request.
  always begin
    @(posedge clk);
    #5;
    if (sbQ.size() > 0) begin
      exp_t e;
      e = sbQ.pop_front();
      check("R1 tl", tlOut, e.tl);
      check("R12 entryDone", entryDone, e.done);
      check("R10 trapErr", trapErr, e.err);
      check("R4 pstate", pstateOut, e.pst);
      check("R5 gl", glOut, e.gl);
      check("R6/R7/R8 cwp", cwpOut, e.cwp);
      check("R9 redirect", redirect, e.redir);
      check("R9 pc", pcOut, e.pc);
      check("R9 npc", npcOut, e.npc);
      check("R9 nnpc", nnpcOut, e.nnpc);
      rdLevel = e.level;
      #1;
      check("R2 tstate", rdTstate, e.tst);
      check("R3 tpc", rdTpc, e.tpc);
      check("R3 tnpc", rdTnpc, e.tnpc);
      check("R3 htstate", rdHtstate, e.hts);
      check("R3 tt", rdTt, e.tt);
    end
  end

  task automatic checkZeroState();
    check("R1 tl reset", tlOut, 0);
    check("R1 outputs reset", {pstateOut, glOut, cwpOut, redirect, entryDone, trapErr}, 0);
    check("R1 pc reset", pcOut | npcOut | nnpcOut, 0);
    for (int l = 0; l < 8; l++) begin
      rdLevel = 3'(l);
      #1;
      check("R1 stack reset", rdTstate | rdTpc | rdTnpc | rdHtstate | rdTt, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    checkZeroState();

    // R6 wrap upward from top window
    doTrap(9'h024, 13'h0100, 12'h0A5, 8'h3C, 8'h80, 3'd7, 3'd3, 3'd0, 64'h1000);
    // R7 spill with CANSAVE=6: 5+8 wraps to 5
    doTrap(9'h085, 13'h1EAA, 12'h5A1, 8'hC3, 8'h19, 3'd5, 3'd6, 3'd2, 64'h2000);
    // R8 fill wrap downward from window 0
    doTrap(9'h0C3, 13'h0A1F, 12'hFFF, 8'h01, 8'hFE, 3'd0, 3'd1, 3'd3, 64'h3000);
    // R8 other type, R5 saturation at MAX_GL, R9 PC held
    doTrap(9'h041, 13'h1FFF, 12'h001, 8'h77, 8'h88, 3'd3, 3'd2, 3'd5, 64'h4000);
    // R8 type with bit 8 set is not fill/spill; R5 above cap
    doTrap(9'h1BF, 13'h0000, 12'h123, 8'h55, 8'hAA, 3'd6, 3'd7, 3'd7, 64'h5000);
    // R7 top edge of spill range, CANSAVE=7: 1+9 -> 2
    doTrap(9'h0BF, 13'h0E5C, 12'h456, 8'h99, 8'h66, 3'd1, 3'd7, 3'd4, 64'h6000);
    // R10 request at MAXTL refused
    doTrap(9'h0C0, 13'h1234, 12'h789, 8'h11, 8'h22, 3'd4, 3'd4, 3'd1, 64'h7000);

    @(negedge clk);
    // R11 out-of-range levels read zero
    rdLevel = 3'd0; #1;
    check("R11 level0", rdTstate | rdTpc | rdTnpc | rdHtstate | rdTt, 0);
    rdLevel = 3'd7; #1;
    check("R11 level7", rdTstate | rdTpc | rdTnpc | rdHtstate | rdTt, 0);
    // R11 earlier level still readable, unchanged
    rdLevel = 3'd2; #1;
    check("R11 level2 tt", rdTt, 9'h085);
    // R12 idle: no pulses, TL held
    check("R12 idle pulses", {entryDone, trapErr, redirect}, 0);
    check("R12 idle tl", tlOut, MTL);

    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    modelReset();
    #1;
    checkZeroState();
    // R8 fill range top edge after reset
    doTrap(9'h0FF, 13'h0104, 12'h00F, 8'hF0, 8'h0F, 3'd0, 3'd0, 3'd4, 64'h8000);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule